// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short first-in, first-out store of instruction bytes between a 16-bit bus and an execution side that consumes one byte at a time. It holds a fetch pointer and, whenever the store has room for a whole word and the execution side is not asking for the bus, it issues a two-byte code fetch. Returned bytes enter the store in address order. The oldest byte is presented on the output together with a valid flag.

The execution side can request the bus for an operand transfer. A code fetch already in flight is always allowed to finish first, and no new code fetch starts while such a request is pending. A flush empties the store and reloads the pointer with a new target address. Any code fetch still in flight at that moment returns data that is thrown away. If the pointer is odd, the fetch is issued at the even word address, only the upper byte is kept, and the pointer becomes even again.

The bus cycle itself is outside this block. A fetch is a one-cycle request pulse carrying the word address. It is answered one or more cycles later by a completion pulse carrying the 16-bit word.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the store is empty, `outValid` is low, and the pointer holds `RESET_ADDR` (default 0), so the first fetch is issued at that address.
- R2: Bytes leave the store in the order they were pushed. `outByte` is the oldest byte while `outValid` is high, and `popReq` with `outValid` high removes exactly that one byte.
- R3: `fetchReq` is a single-cycle pulse. It is raised only when no fetch is in flight, `opReq` and `flushReq` are low, and at most `QDEPTH-2` bytes are stored. It is raised in every cycle where all of these hold. `fetchAddr` is the pointer with bit 0 forced to 0.
- R4: A completed fetch at an even pointer pushes `fetchData[7:0]` first and then `fetchData[15:8]`, and advances the pointer by 2.
- R5: A completed fetch at an odd pointer pushes only `fetchData[15:8]` and advances the pointer by 1, so the next fetch is word aligned.
- R6: `opGrant` is high exactly when `opReq` is high and no fetch is in flight. From the cycle a fetch is issued until the cycle after its `fetchDone`, an operand request stays ungranted.
- R7: With the store full and no operand request, no fetch is issued and the bus stays idle.
- R8: A `flushReq` empties the store in the next cycle and loads the pointer from `flushAddr`. A `popReq` or completion in the same cycle has no effect on the store.
- R9: The data of a fetch that was in flight when a flush occurred is discarded, including a completion in the flush cycle itself.
- R10: A `fetchDone` while no fetch is in flight is ignored.
- R11: A `popReq` while the store is empty has no effect; the consumer stalls until a byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flushReq | input | 1 | Branch taken: empty the store and restart |
| flushAddr | input | ADDR_W | New fetch target, sampled with `flushReq` |
| popReq | input | 1 | Consumer takes the presented byte |
| outValid | output | 1 | Store is not empty |
| outByte | output | 8 | Oldest stored byte |
| opReq | input | 1 | Execution side wants the bus for an operand cycle |
| opGrant | output | 1 | Operand cycle may use the bus |
| fetchReq | output | 1 | One-cycle code fetch request |
| fetchAddr | output | ADDR_W | Word-aligned fetch address |
| fetchDone | input | 1 | Bus completes the fetch in flight |
| fetchData | input | 16 | Word returned with `fetchDone` |

## Verification
The bench targets fetches that complete in the same cycle as a flush. A design that only guards the in-flight case would push stale bytes after a branch. It also flushes to odd targets, where a design that keeps both bytes or fails to realign the pointer would present the wrong byte. Sustained consumer stalls fill the store to the brim, which shows up any fetch issued with only one free slot or any overflow. Operand requests land while a fetch is outstanding, and bogus completions arrive when nothing is in flight. A design that grants early, or that accepts the bogus completion, diverges from the byte-by-byte reference at once.

// File: rtl/pq_pkg.sv
package pq_pkg;
  // strobes from the control to the byte store
  typedef struct packed {
    logic       flush;    // empty the store, load the pointer
    logic       pop;      // remove the head byte
    logic [1:0] pushCnt;  // bytes accepted from the bus this cycle
  } qStrobe_t;
endpackage

// File: rtl/pq_data.sv
module pq_data
  import pq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int QDEPTH     = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int CNT_W      = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic [15:0]       fetchData,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] ptr,
  output logic [7:0]        headByte
);
  logic [7:0]       mem [QDEPTH];
  logic [7:0]       nxt [QDEPTH];
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] baseNext;
  logic [7:0]       firstByte;

  // slot where the first new byte lands, after any pop this cycle
  assign base      = count - CNT_W'(strobe.pop);
  assign baseNext  = base + CNT_W'(1);
  // an odd pointer keeps only the upper half of the word
  assign firstByte = ptr[0] ? fetchData[15:8] : fetchData[7:0];
  assign headByte  = mem[0];

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      nxt[i] = mem[i];
      if (strobe.pop) nxt[i] = mem[(i + 1) % QDEPTH];
      if (strobe.pushCnt != 2'd0 && base == CNT_W'(i)) nxt[i] = firstByte;
      if (strobe.pushCnt == 2'd2 && baseNext == CNT_W'(i)) nxt[i] = fetchData[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) mem[i] <= '0;
    end else if (!strobe.flush) begin
      for (int i = 0; i < QDEPTH; i++) mem[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      ptr   <= RESET_ADDR;
    end else if (strobe.flush) begin
      count <= '0;
      ptr   <= flushAddr;
    end else begin
      count <= count - CNT_W'(strobe.pop) + CNT_W'(strobe.pushCnt);
      ptr   <= ptr + ADDR_W'(strobe.pushCnt);
    end
  end
endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int QDEPTH = 6,
  parameter int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushReq,
  input  logic             popReq,
  input  logic             opReq,
  input  logic             fetchDone,
  input  logic [CNT_W-1:0] count,
  input  logic             ptrOdd,
  output qStrobe_t         strobe,
  output logic             fetchReq,
  output logic             opGrant
);
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(QDEPTH - 2);

  logic inFlight;
  logic discard;
  logic accept;

  // a fetch starts only with a free word of room and an idle bus
  assign fetchReq = !inFlight && !opReq && !flushReq && (count <= ROOM_LIMIT);
  // the in-flight fetch always finishes before an operand cycle
  assign opGrant  = opReq && !inFlight;
  assign accept   = fetchDone && inFlight && !discard && !flushReq;

  always_comb begin
    strobe.flush   = flushReq;
    strobe.pop     = popReq && (count != '0) && !flushReq;
    strobe.pushCnt = accept ? (ptrOdd ? 2'd1 : 2'd2) : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      discard  <= 1'b0;
    end else begin
      if (fetchReq)       inFlight <= 1'b1;
      else if (fetchDone) inFlight <= 1'b0;
      if (fetchDone)                 discard <= 1'b0;
      else if (flushReq && inFlight) discard <= 1'b1;
    end
  end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int QDEPTH = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              popReq,
  output logic              outValid,
  output logic [7:0]        outByte,
  input  logic              opReq,
  output logic              opGrant,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchDone,
  input  logic [15:0]       fetchData
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  qStrobe_t          strobe;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] ptr;

  pq_ctrl #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .popReq(popReq),
    .opReq(opReq), .fetchDone(fetchDone), .count(count), .ptrOdd(ptr[0]),
    .strobe(strobe), .fetchReq(fetchReq), .opGrant(opGrant)
  );

  pq_data #(.ADDR_W(ADDR_W), .QDEPTH(QDEPTH), .RESET_ADDR(RESET_ADDR), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flushAddr(flushAddr),
    .fetchData(fetchData), .count(count), .ptr(ptr), .headByte(outByte)
  );

  assign outValid  = (count != '0);
  assign fetchAddr = {ptr[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int QDEPTH = 6,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             flushReq,
  input logic             opReq,
  input logic             fetchReq,
  input logic             fetchDone,
  input logic             opGrant,
  input logic             outValid,
  input logic [CNT_W-1:0] count
);
  // R3: the store never holds more than its depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= QDEPTH);

  // R3: a fetch request is a single-cycle pulse
  assert_fetch_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> !fetchReq);

  // R3: a fetch is only issued with a free word of room
  assert_fetch_room_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (int'(count) <= QDEPTH - 2));

  // R6: once a fetch is issued the operand cycle waits for it
  assert_grant_waits_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> !opGrant);

  // R7: a full store keeps the bus idle
  assert_full_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(count) == QDEPTH) |-> !fetchReq);

  // R8: a flush leaves the store empty
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !outValid);

  // R11: an empty store stays empty without a completion
  assert_stall_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !fetchDone) |=> !outValid);

  // R4: at most one word enters per cycle
  assert_push_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= int'($past(count)) + 2);
endmodule

bind prefetch_queue pq_checker #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .flushReq(flushReq), .opReq(opReq),
  .fetchReq(fetchReq), .fetchDone(fetchDone), .opGrant(opGrant),
  .outValid(outValid), .count(count)
);

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  localparam int ADDR_W = 20;
  localparam int QDEPTH = 6;
  localparam int CYCLES = 4000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              flushReq = 1'b0;
  logic [ADDR_W-1:0] flushAddr = '0;
  logic              popReq = 1'b0;
  logic              outValid;
  logic [7:0]        outByte;
  logic              opReq = 1'b0;
  logic              opGrant;
  logic              fetchReq;
  logic [ADDR_W-1:0] fetchAddr;
  logic              fetchDone = 1'b0;
  logic [15:0]       fetchData = '0;

  prefetch_queue #(.ADDR_W(ADDR_W), .QDEPTH(QDEPTH)) u_dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [7:0]        mq[$];
  logic [ADDR_W-1:0] mPtr = '0;
  bit                mInFlight = 1'b0;
  bit                mDiscard = 1'b0;
  string             ctx = "R1";

  // bus responder state
  int                respTimer = 0;
  logic [ADDR_W-1:0] respAddr = '0;
  int unsigned       rng = 32'h1234_5677;

  function automatic logic [7:0] byteAt(logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic int unsigned nextRand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit expStart, accept, fr;
    int popPct, opPct;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    chk(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(fetchReq == 1'b1 && fetchAddr == '0, "R1", "first fetch at reset address",
        fetchAddr, 0);
    for (int c = 0; c < CYCLES; c++) begin
      // stimulus, changing per phase
      case ((c / 400) % 5)
        0: begin popPct = 0;  opPct = 0;  end
        1: begin popPct = 50; opPct = 10; end
        2: begin popPct = 95; opPct = 5;  end
        3: begin popPct = 20; opPct = 30; end
        default: begin popPct = 70; opPct = 15; end
      endcase
      popReq    = (nextRand() % 100) < popPct;
      opReq     = (nextRand() % 100) < opPct;
      flushReq  = (nextRand() % 40) == 0;
      flushAddr = ADDR_W'(nextRand());
      if (respTimer == 1) begin
        fetchDone = 1'b1;
        fetchData = {byteAt(respAddr + 1), byteAt(respAddr)};
      end else begin
        fetchDone = (respTimer == 0) && !mInFlight && ((nextRand() % 12) == 0);
        fetchData = 16'(nextRand());
      end
      #2;
      // compare against the model
      chk(outValid == (mq.size() != 0), ctx, "outValid", outValid, mq.size() != 0);
      if (mq.size() != 0)
        chk(outByte == mq[0], ctx, "outByte", outByte, mq[0]);
      expStart = !mInFlight && !opReq && !flushReq && (mq.size() <= QDEPTH - 2);
      chk(fetchReq == expStart,
          (mq.size() == QDEPTH && !opReq && !mInFlight) ? "R7" : "R3",
          "fetchReq", fetchReq, expStart);
      if (fetchReq && expStart)
        chk(fetchAddr == {mPtr[ADDR_W-1:1], 1'b0}, mPtr[0] ? "R5" : "R3",
            "fetchAddr", fetchAddr, {mPtr[ADDR_W-1:1], 1'b0});
      chk(opGrant == (opReq && !mInFlight), "R6", "opGrant", opGrant, opReq && !mInFlight);
      fr = fetchReq;
      @(posedge clk);
      // model update from the inputs of this cycle
      accept = fetchDone && mInFlight && !mDiscard && !flushReq;
      ctx = "R2";
      if (flushReq) begin
        mq.delete();
        mPtr = flushAddr;
        ctx = (fetchDone && mInFlight) ? "R9" : "R8";
      end else begin
        if (popReq && mq.size() != 0) void'(mq.pop_front());
        else if (popReq) ctx = "R11";
        if (fetchDone && !mInFlight) ctx = "R10";
        else if (fetchDone && mDiscard) ctx = "R9";
        if (accept) begin
          if (mPtr[0]) begin
            mq.push_back(byteAt(mPtr));
            mPtr = mPtr + 1;
            ctx = "R5";
          end else begin
            mq.push_back(byteAt(mPtr));
            mq.push_back(byteAt(mPtr + 1));
            mPtr = mPtr + 2;
            ctx = "R4";
          end
        end
      end
      if (expStart)       mInFlight = 1'b1;
      else if (fetchDone) mInFlight = 1'b0;
      if (fetchDone)                     mDiscard = 1'b0;
      else if (flushReq && mInFlight)    mDiscard = 1'b1;
      // responder
      if (fr) begin
        respTimer = 1 + int'(nextRand() % 3);
        respAddr  = fetchAddr;
      end else if (respTimer > 0) begin
        respTimer--;
      end
      @(negedge clk);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule